// File: doc/BRIEF.md
# Flash read-protection guard

This block enforces code-readout protection around an on-chip nonvolatile program array. While reset is held, it samples the protection byte that the array presents from its highest location (address 7FFFH). It latches a lock bit from that byte and keeps it until the next reset or until a full erase completes. Rewriting the protection byte while running leaves the lock alone. Freshly loaded code, the protection byte included, can therefore still be read back before the new setting applies.

Every access carries a 2-bit origin tag that says where the requesting code came from: internal code, external code, boot code or the parallel programming port. While locked, the guard filters reads and command-register writes by that tag. Internal code keeps full access. Denied reads return all-ones. Denied command writes leave the register unchanged and set a sticky violation flag. A full-erase completion pulse from the array releases the lock at once.

Top module: `fprot_guard`

## Requirements
- R1: A protection byte of 50H sampled during reset sets `lock` to 1 from the first cycle after reset.
- R2: A protection byte of 00H or FFH sampled during reset leaves `lock` at 0.
- R3: Any other protection byte value, including every single-bit corruption of 50H (for example 51H, 10H, D0H), sets `lock` to 1, so that faults fail safe.
- R4: A change of `key_byte` while `rst` is low has no effect on `lock`; the new value takes effect only after the next reset.
- R5: While locked, a read with origin external (1) or parallel port (3) is denied: `rd_deny`=1, `rd_grant`=0 and `rd_data`=FFH regardless of the array data.
- R6: While locked, a read with origin internal (0) or boot (2) is granted and `rd_data` equals `rd_arr_data`.
- R7: While locked, a command write from origin external (1), boot (2) or parallel port (3) is refused (`cw_deny`=1) when its low 4 bits, the command field, are not the full-erase code CH. `cmd_reg` then keeps its value and `viol` becomes 1 and stays 1 until reset.
- R8: While locked, a command write whose command field is CH is accepted from any origin, and `cmd_reg` takes the written byte.
- R9: While locked, any command write with origin internal (0) is accepted.
- R10: A one-cycle `erase_done` pulse clears `lock` on the next cycle, after which external reads and writes are granted.
- R11: While unlocked, all reads and command writes from every origin are granted, and `viol` stays 0.
- R12: Reset clears `cmd_reg` to 00H and `viol` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; protection byte is sampled while high |
| key_byte | input | 8 | Protection byte as stored at the top array address |
| erase_done | input | 1 | One-cycle pulse when a full array erase completes |
| rd_req | input | 1 | Read request into the array |
| rd_org | input | 2 | Read origin: 0 internal, 1 external, 2 boot, 3 parallel port |
| rd_arr_data | input | 8 | Data from the array for the current read |
| rd_data | output | 8 | Filtered read data (FFH when denied) |
| rd_grant | output | 1 | Read allowed |
| rd_deny | output | 1 | Read refused |
| cw_en | input | 1 | Command register write strobe |
| cw_org | input | 2 | Write origin, same encoding as `rd_org` |
| cw_data | input | 8 | Byte written; bits 3:0 are the command field |
| cw_grant | output | 1 | Write accepted this cycle |
| cw_deny | output | 1 | Write refused this cycle |
| cmd_reg | output | 8 | Current command register contents |
| lock | output | 1 | Latched protection state |
| viol | output | 1 | Sticky flag: a refused command write occurred |

## Verification
The assertions watch, cycle by cycle, that the lock never rises outside reset, that locked reads from external code or the parallel port come back as all-ones, that a refused write leaves the command register untouched and raises the violation flag, and that an erase-completion pulse drops the lock. The key decoding across the distinct byte values, the reset-only timing of a new protection byte, and the change of access rights after an erase all depend on sequences of resets and key values. Only the bench's scenarios can show those.

// File: rtl/fprot_pkg.sv
package fprot_pkg;

    typedef enum logic [1:0] {
        ORG_INT  = 2'd0,
        ORG_EXT  = 2'd1,
        ORG_BOOT = 2'd2,
        ORG_PAR  = 2'd3
    } org_e;

    // Only the erased patterns leave protection off; 50H and every
    // corrupted value lock, so a flipped bit cannot unlock the part.
    function automatic logic key_locks(input logic [7:0] k);
        return !((k == 8'h00) || (k == 8'hFF));
    endfunction

    function automatic logic read_blocked(input logic locked, input org_e o);
        return locked && ((o == ORG_EXT) || (o == ORG_PAR));
    endfunction

    function automatic logic write_restricted(input logic locked, input org_e o);
        return locked && (o != ORG_INT);
    endfunction

endpackage

// File: rtl/fprot_key_latch.sv
module fprot_key_latch
    import fprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] key_byte,
    input  logic       erase_done,
    output logic       lock
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= key_locks(key_byte);
        else if (erase_done)
            lock_q <= 1'b0;
    end

    assign lock = lock_q;
endmodule

// File: rtl/fprot_rd_filter.sv
module fprot_rd_filter
    import fprot_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          lock,
    input  logic          rd_req,
    input  logic [1:0]    rd_org,
    input  logic [DW-1:0] rd_arr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_grant,
    output logic          rd_deny
);
    logic blocked;

    assign blocked  = read_blocked(lock, org_e'(rd_org));
    assign rd_grant = rd_req && !blocked;
    assign rd_deny  = rd_req && blocked;

    for (genvar i = 0; i < DW; i++) begin : g_fill
        assign rd_data[i] = blocked ? 1'b1 : rd_arr_data[i];
    end
endmodule

// File: rtl/fprot_cmd_gate.sv
module fprot_cmd_gate
    import fprot_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          FW        = 4,
    parameter logic [FW-1:0] ERASE_ALL = 4'hC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          cw_en,
    input  logic [1:0]    cw_org,
    input  logic [DW-1:0] cw_data,
    output logic          cw_grant,
    output logic          cw_deny,
    output logic [DW-1:0] cmd_reg,
    output logic          viol
);
    logic          allowed;
    logic [DW-1:0] cmd_q;
    logic          viol_q;

    always_comb begin
        allowed = !write_restricted(lock, org_e'(cw_org))
                  || (cw_data[FW-1:0] == ERASE_ALL);
    end

    assign cw_grant = cw_en && allowed;
    assign cw_deny  = cw_en && !allowed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            viol_q <= 1'b0;
        end else if (cw_en) begin
            if (allowed)
                cmd_q <= cw_data;
            else
                viol_q <= 1'b1;
        end
    end

    assign cmd_reg = cmd_q;
    assign viol    = viol_q;
endmodule

// File: rtl/fprot_guard.sv
module fprot_guard
    import fprot_pkg::*;
#(
    parameter int            DW        = 8,
    parameter int            FW        = 4,
    parameter logic [FW-1:0] ERASE_ALL = 4'hC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    key_byte,
    input  logic          erase_done,
    input  logic          rd_req,
    input  logic [1:0]    rd_org,
    input  logic [DW-1:0] rd_arr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_grant,
    output logic          rd_deny,
    input  logic          cw_en,
    input  logic [1:0]    cw_org,
    input  logic [DW-1:0] cw_data,
    output logic          cw_grant,
    output logic          cw_deny,
    output logic [DW-1:0] cmd_reg,
    output logic          lock,
    output logic          viol
);
    logic lock_w;

    fprot_key_latch u_key (
        .clk        (clk),
        .rst        (rst),
        .key_byte   (key_byte),
        .erase_done (erase_done),
        .lock       (lock_w)
    );

    fprot_rd_filter #(.DW(DW)) u_rd (
        .lock        (lock_w),
        .rd_req      (rd_req),
        .rd_org      (rd_org),
        .rd_arr_data (rd_arr_data),
        .rd_data     (rd_data),
        .rd_grant    (rd_grant),
        .rd_deny     (rd_deny)
    );

    fprot_cmd_gate #(.DW(DW), .FW(FW), .ERASE_ALL(ERASE_ALL)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .lock     (lock_w),
        .cw_en    (cw_en),
        .cw_org   (cw_org),
        .cw_data  (cw_data),
        .cw_grant (cw_grant),
        .cw_deny  (cw_deny),
        .cmd_reg  (cmd_reg),
        .viol     (viol)
    );

    assign lock = lock_w;
endmodule

// File: rtl/fprot_guard_chk.sv
module fprot_guard_chk #(
    parameter int            DW        = 8,
    parameter int            FW        = 4,
    parameter logic [FW-1:0] ERASE_ALL = 4'hC
) (
    input logic          clk,
    input logic          rst,
    input logic          erase_done,
    input logic          rd_req,
    input logic [1:0]    rd_org,
    input logic [DW-1:0] rd_data,
    input logic          rd_deny,
    input logic          cw_en,
    input logic [1:0]    cw_org,
    input logic [DW-1:0] cw_data,
    input logic [DW-1:0] cmd_reg,
    input logic          lock,
    input logic          viol
);
    // R4
    lock_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$rose(lock));

    // R5
    locked_rd_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && lock && rd_org[0]) |-> (rd_deny && (rd_data == {DW{1'b1}})));

    // R7
    refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cw_en && lock && (cw_org != 2'd0) && (cw_data[FW-1:0] != ERASE_ALL))
        |=> ($stable(cmd_reg) && viol));

    // R10
    erase_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        erase_done |=> !lock);

    // R11
    viol_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(viol) |-> $past(cw_en && lock));

    // R12
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((cmd_reg == '0) && !viol));
endmodule

bind fprot_guard fprot_guard_chk #(.DW(DW), .FW(FW), .ERASE_ALL(ERASE_ALL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .erase_done (erase_done),
    .rd_req     (rd_req),
    .rd_org     (rd_org),
    .rd_data    (rd_data),
    .rd_deny    (rd_deny),
    .cw_en      (cw_en),
    .cw_org     (cw_org),
    .cw_data    (cw_data),
    .cmd_reg    (cmd_reg),
    .lock       (lock),
    .viol       (viol)
);

// File: tb/sim_fprot_guard.sv
`timescale 1ns/1ps
module sim_fprot_guard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] key_byte = 8'h00;
    logic       erase_done = 1'b0;
    logic       rd_req = 1'b0;
    logic [1:0] rd_org = 2'd0;
    logic [7:0] rd_arr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_grant, rd_deny;
    logic       cw_en = 1'b0;
    logic [1:0] cw_org = 2'd0;
    logic [7:0] cw_data = 8'h00;
    logic       cw_grant, cw_deny;
    logic [7:0] cmd_reg;
    logic       lock, viol;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fprot_guard u0 (
        .clk(clk), .rst(rst), .key_byte(key_byte), .erase_done(erase_done),
        .rd_req(rd_req), .rd_org(rd_org), .rd_arr_data(rd_arr_data),
        .rd_data(rd_data), .rd_grant(rd_grant), .rd_deny(rd_deny),
        .cw_en(cw_en), .cw_org(cw_org), .cw_data(cw_data),
        .cw_grant(cw_grant), .cw_deny(cw_deny),
        .cmd_reg(cmd_reg), .lock(lock), .viol(viol)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] key);
        @(negedge clk);
        key_byte = key;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [1:0] org, input logic [7:0] arr,
                           input logic [7:0] exp_data, input logic exp_grant);
        @(negedge clk);
        rd_req = 1'b1; rd_org = org; rd_arr_data = arr;
        #2;
        chk(req, "rd_data", rd_data, exp_data);
        chk(req, "rd_grant", rd_grant, exp_grant);
        chk(req, "rd_deny", rd_deny, !exp_grant);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic do_write(input string req, input logic [1:0] org, input logic [7:0] d,
                            input logic exp_grant, input logic [7:0] exp_cmd,
                            input logic exp_viol);
        @(negedge clk);
        cw_en = 1'b1; cw_org = org; cw_data = d;
        #2;
        chk(req, "cw_grant", cw_grant, exp_grant);
        chk(req, "cw_deny", cw_deny, !exp_grant);
        @(negedge clk);
        cw_en = 1'b0;
        chk(req, "cmd_reg", cmd_reg, exp_cmd);
        chk(req, "viol", viol, exp_viol);
    endtask

    task automatic t_reset_state;
        do_reset(8'h00);
        chk("R12", "cmd_reg after reset", cmd_reg, 8'h00);
        chk("R12", "viol after reset", viol, 1'b0);
        chk("R2", "lock key 00", lock, 1'b0);
        do_reset(8'hFF);
        chk("R2", "lock key FF", lock, 1'b0);
    endtask

    task automatic t_key_decode;
        do_reset(8'h50);
        chk("R1", "lock key 50", lock, 1'b1);
        do_reset(8'h51);
        chk("R3", "lock key 51", lock, 1'b1);
        do_reset(8'h10);
        chk("R3", "lock key 10", lock, 1'b1);
        do_reset(8'hD0);
        chk("R3", "lock key D0", lock, 1'b1);
        do_reset(8'hFE);
        chk("R3", "lock key FE", lock, 1'b1);
    endtask

    task automatic t_no_live_update;
        do_reset(8'h00);
        @(negedge clk);
        key_byte = 8'h50;
        repeat (4) @(negedge clk);
        chk("R4", "lock after key rewrite", lock, 1'b0);
        do_read("R4", 2'd1, 8'h77, 8'h77, 1'b1);
        do_reset(8'h50);
        chk("R4", "lock after next reset", lock, 1'b1);
        @(negedge clk);
        key_byte = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R4", "lock held on key clear", lock, 1'b1);
    endtask

    task automatic t_locked_reads;
        do_reset(8'h50);
        do_read("R5", 2'd1, 8'hA5, 8'hFF, 1'b0);
        do_read("R5", 2'd3, 8'h00, 8'hFF, 1'b0);
        do_read("R6", 2'd0, 8'h3C, 8'h3C, 1'b1);
        do_read("R6", 2'd2, 8'h81, 8'h81, 1'b1);
    endtask

    task automatic t_locked_writes;
        do_reset(8'h50);
        do_write("R9", 2'd0, 8'h45, 1'b1, 8'h45, 1'b0);
        do_write("R9", 2'd0, 8'h4A, 1'b1, 8'h4A, 1'b0);
        do_write("R7", 2'd1, 8'h45, 1'b0, 8'h4A, 1'b1);
        do_write("R7", 2'd2, 8'h41, 1'b0, 8'h4A, 1'b1);
        do_write("R7", 2'd3, 8'h00, 1'b0, 8'h4A, 1'b1);
        do_write("R8", 2'd1, 8'h4C, 1'b1, 8'h4C, 1'b1);
        do_write("R8", 2'd2, 8'h0C, 1'b1, 8'h0C, 1'b1);
        do_write("R8", 2'd3, 8'h4C, 1'b1, 8'h4C, 1'b1);
    endtask

    task automatic t_erase_unlock;
        do_reset(8'h50);
        chk("R10", "locked before erase", lock, 1'b1);
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        chk("R10", "lock after erase", lock, 1'b0);
        do_read("R10", 2'd1, 8'h5A, 8'h5A, 1'b1);
        do_write("R10", 2'd1, 8'h45, 1'b1, 8'h45, 1'b0);
    endtask

    task automatic t_unlocked_access;
        do_reset(8'hFF);
        do_read("R11", 2'd1, 8'hC3, 8'hC3, 1'b1);
        do_read("R11", 2'd3, 8'h12, 8'h12, 1'b1);
        do_write("R11", 2'd1, 8'h43, 1'b1, 8'h43, 1'b0);
        do_write("R11", 2'd2, 8'h41, 1'b1, 8'h41, 1'b0);
        do_write("R11", 2'd3, 8'h47, 1'b1, 8'h47, 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_key_decode();
        t_no_live_update();
        t_locked_reads();
        t_locked_writes();
        t_erase_unlock();
        t_unlocked_access();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end
endmodule